// File: doc/BRIEF.md
# Reset Request Arbiter with Cause Tracking

This block collects every reset source of a subsystem and turns them into one reset request. It sends the request with a cause code and with a vector that has one bit per source. There are two kinds of source. Conditional external requests pass only when their enable bit is set. The escalation reset and the main-power glitch reset always pass. A software reset request is a separate source, and it is counted in the vector and in the status like any other source.

While a reset is being serviced, the block holds the peripheral clock enable low. It also loads a status word that records which sources caused the reset.

The block also orders resets against low-power wakeups. A wakeup counts only while the low-power indication is high. A reset counts in both the active and the low-power state. When a reset and a wakeup arrive close together, they are serviced one at a time, in the order they arrived. If both arrive in the same cycle, the reset goes first. Each service lasts a fixed, parameterised number of cycles. At least one idle cycle separates two services.

Top module: `rstarb_top`

## Requirements
- R1: Conditional request bit i appears in the output vector only when enable bit i is set. The conditional requests occupy vector bits [N_COND-1:0].
- R2: A reset request is serviced whether the low-power indication is low or high.
- R3: While a reset is serviced, `rst_req_o` is high, `cause_o` is 2'd2 (hardware request), and `vec_o` equals the unconditional requests OR-ed with the enabled conditional requests. At all other times `cause_o` is 2'd0 and `vec_o` is 0.
- R4: A low level on `main_pwr_ni` is a power-glitch request. It sets vector bit N_COND+2 whatever the enables are. The escalation request sets bit N_COND+1, also whatever the enables are.
- R5: A software reset request sets vector bit N_COND and is recorded in the status.
- R6: `clk_en_o` is low in every cycle of a reset service and high in the idle cycle after it.
- R7: A reset and a wakeup that arrive in different cycles are serviced in arrival order, one after the other. `rst_req_o` and `wake_o` are never high together.
- R8: When a reset and a wakeup arrive in the same cycle, the reset is serviced first.
- R9: `status_o` takes the vector of a reset when that reset's service starts. It then keeps that value until the next reset service starts.
- R10: A request held for one cycle starts a service on the next clock edge. The service lasts exactly RST_CYCLES cycles for a reset and WAKE_CYCLES cycles for a wakeup.
- R11: A wakeup that arrives while the low-power indication is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_req_i | input | N_COND | Conditional external reset requests |
| cond_en_i | input | N_COND | Enable bit for each conditional request |
| sw_req_i | input | 1 | Software reset request |
| esc_req_i | input | 1 | Escalation reset request, always passes |
| main_pwr_ni | input | 1 | Main power good, active low; low means glitch |
| low_pwr_i | input | 1 | High while the subsystem is in low power |
| wake_i | input | 1 | Wakeup event |
| rst_req_o | output | 1 | Reset request being serviced |
| cause_o | output | 2 | Cause code: 0 none, 2 hardware request |
| vec_o | output | N_COND+3 | Source vector of the reset being serviced |
| status_o | output | N_COND+3 | Source vector of the last serviced reset |
| clk_en_o | output | 1 | Peripheral clock enable |
| wake_o | output | 1 | Wakeup being serviced |

## Verification
The bench sweeps every combination of the five sources against every enable pattern. A mask applied the wrong way round would let a disabled conditional request through, or block an enabled one. A mask applied to all sources would also drop the escalation and glitch requests. A combination that has no effective source must leave both the outputs and the status untouched. A design that loaded the status on every request would fail that check.

The ordering cases place a reset and a wakeup two cycles apart, one cycle apart and in the same cycle, in both orders. A design that let a later wakeup overtake an earlier reset, or that picked the wakeup on a tie, would show the two services in the wrong sequence. A wakeup that arrives outside low power is also driven, and it must produce no wakeup service.

// File: rtl/rstarb_pkg.sv
package rstarb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RST  = 2'd1,
        ST_WAKE = 2'd2
    } arb_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_HWREQ = 2'd2
    } cause_e;

endpackage

// File: rtl/rstarb_src_mask.sv
// Forms the per-source request vector: gated conditional bits, then
// software, escalation and power-glitch bits.
module rstarb_src_mask #(
    parameter int N_COND = 2,
    localparam int NV    = N_COND + 3
) (
    input  logic [N_COND-1:0] cond_req_i,
    input  logic [N_COND-1:0] cond_en_i,
    input  logic              sw_req_i,
    input  logic              esc_req_i,
    input  logic              main_pwr_ni,
    output logic [NV-1:0]     req_vec_o
);

    for (genvar i = 0; i < N_COND; i++) begin : g_cond
        assign req_vec_o[i] = cond_req_i[i] & cond_en_i[i];
    end

    assign req_vec_o[N_COND]   = sw_req_i;
    assign req_vec_o[N_COND+1] = esc_req_i;
    assign req_vec_o[N_COND+2] = ~main_pwr_ni;

endmodule

// File: rtl/rstarb_order.sv
// Keeps pending reset sources and a pending wakeup, and remembers which
// of the two arrived first.
module rstarb_order #(
    parameter int NV = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NV-1:0] req_vec_i,
    input  logic          wake_evt_i,
    input  logic          take_rst_i,
    input  logic          take_wake_i,
    output logic [NV-1:0] pend_vec_o,
    output logic          wake_pend_o,
    output logic          rst_first_o
);

    typedef struct packed {
        logic [NV-1:0] pend;
        logic          wake;
        logic          first;
    } ord_t;

    ord_t ord_d, ord_q;

    always_comb begin
        pend_vec_o  = ord_q.pend | req_vec_i;
        wake_pend_o = ord_q.wake | wake_evt_i;
        // A reset that becomes pending is first unless a wakeup already waits.
        rst_first_o = (|ord_q.pend) ? ord_q.first : ~ord_q.wake;

        ord_d       = ord_q;
        ord_d.pend  = take_rst_i  ? '0   : pend_vec_o;
        ord_d.wake  = take_wake_i ? 1'b0 : wake_pend_o;
        // Once a wakeup is taken, any waiting reset precedes later wakeups.
        ord_d.first = take_wake_i ? 1'b1 : rst_first_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ord_q <= '0;
        else        ord_q <= ord_d;
    end

endmodule

// File: rtl/rstarb_top.sv
module rstarb_top
    import rstarb_pkg::*;
#(
    parameter int N_COND      = 2,
    parameter int RST_CYCLES  = 3,
    parameter int WAKE_CYCLES = 2,
    localparam int NV         = N_COND + 3,
    localparam int MAXC       = (RST_CYCLES > WAKE_CYCLES) ? RST_CYCLES : WAKE_CYCLES,
    localparam int CW         = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] cond_req_i,
    input  logic [N_COND-1:0] cond_en_i,
    input  logic              sw_req_i,
    input  logic              esc_req_i,
    input  logic              main_pwr_ni,
    input  logic              low_pwr_i,
    input  logic              wake_i,
    output logic              rst_req_o,
    output logic [1:0]        cause_o,
    output logic [NV-1:0]     vec_o,
    output logic [NV-1:0]     status_o,
    output logic              clk_en_o,
    output logic              wake_o
);

    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

    typedef struct packed {
        arb_st_e       st;
        logic [CW-1:0] cnt;
        logic [NV-1:0] vec;
        logic [NV-1:0] stat;
    } arb_t;

    arb_t s_d, s_q;

    logic [NV-1:0] req_vec, pend_vec;
    logic          wake_pend, rst_first, take_rst, take_wake, wake_evt;

    assign wake_evt = wake_i & low_pwr_i;

    rstarb_src_mask #(.N_COND(N_COND)) u_mask (
        .cond_req_i  (cond_req_i),
        .cond_en_i   (cond_en_i),
        .sw_req_i    (sw_req_i),
        .esc_req_i   (esc_req_i),
        .main_pwr_ni (main_pwr_ni),
        .req_vec_o   (req_vec)
    );

    rstarb_order #(.NV(NV)) u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vec_i   (req_vec),
        .wake_evt_i  (wake_evt),
        .take_rst_i  (take_rst),
        .take_wake_i (take_wake),
        .pend_vec_o  (pend_vec),
        .wake_pend_o (wake_pend),
        .rst_first_o (rst_first)
    );

    always_comb begin
        s_d       = s_q;
        take_rst  = 1'b0;
        take_wake = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.cnt = '0;
                if ((|pend_vec) && (!wake_pend || rst_first)) begin
                    take_rst = 1'b1;
                    s_d.st   = ST_RST;
                    s_d.vec  = pend_vec;
                    s_d.stat = pend_vec;
                end else if (wake_pend) begin
                    take_wake = 1'b1;
                    s_d.st    = ST_WAKE;
                end
            end
            ST_RST: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == RST_LAST) begin
                    s_d.st  = ST_IDLE;
                    s_d.vec = '0;
                end
            end
            ST_WAKE: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == WAKE_LAST) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, vec: '0, stat: '0};
        else        s_q <= s_d;
    end

    assign rst_req_o = (s_q.st == ST_RST);
    assign wake_o    = (s_q.st == ST_WAKE);
    assign clk_en_o  = ~rst_req_o;
    assign cause_o   = rst_req_o ? CAUSE_HWREQ : CAUSE_NONE;
    assign vec_o     = rst_req_o ? s_q.vec : '0;
    assign status_o  = s_q.stat;

endmodule

// File: rtl/rstarb_chk.sv
module rstarb_chk #(
    parameter int N_COND = 2,
    localparam int NV    = N_COND + 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rst_req_o,
    input logic          wake_o,
    input logic          clk_en_o,
    input logic [1:0]    cause_o,
    input logic [NV-1:0] vec_o,
    input logic [NV-1:0] status_o
);

    AST_RST_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (vec_o != '0));                                      // R3
    AST_CAUSE_HWREQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (cause_o == 2'd2));                                  // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_o |-> (cause_o == 2'd0 && vec_o == '0));                  // R3
    AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !clk_en_o);                                          // R6
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && wake_o));                                           // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_req_o) |-> $stable(status_o));                          // R9
    AST_STATUS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (status_o == vec_o));                                // R9

endmodule

bind rstarb_top rstarb_chk #(.N_COND(N_COND)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req_o (rst_req_o),
    .wake_o    (wake_o),
    .clk_en_o  (clk_en_o),
    .cause_o   (cause_o),
    .vec_o     (vec_o),
    .status_o  (status_o)
);

// File: tb/rstarb_top_tb.sv
module rstarb_top_tb;

    localparam int NC = 2;
    localparam int NV = NC + 3;
    localparam int RC = 3;
    localparam int WC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] cond_req = '0, cond_en = '0;
    logic          sw_req = 1'b0, esc_req = 1'b0, main_pwr_n = 1'b1;
    logic          low_pwr = 1'b0, wake = 1'b0;
    logic          rst_req, clk_en, wake_o;
    logic [1:0]    cause;
    logic [NV-1:0] vec, status;

    int checks = 0;
    int fails  = 0;
    logic [NV-1:0] last_stat = '0;

    always #2 clk = ~clk;

    rstarb_top #(.N_COND(NC), .RST_CYCLES(RC), .WAKE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cond_req_i(cond_req), .cond_en_i(cond_en),
        .sw_req_i(sw_req), .esc_req_i(esc_req), .main_pwr_ni(main_pwr_n),
        .low_pwr_i(low_pwr), .wake_i(wake), .rst_req_o(rst_req), .cause_o(cause),
        .vec_o(vec), .status_o(status), .clk_en_o(clk_en), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle pulse of the sources in code c with enables e.
    task automatic pulse(input int c, input int e, input logic lp);
        logic [NV-1:0] exp;
        exp = {~(c[4] == 1'b0) ? 1'b1 : 1'b0, c[3], c[2], c[1:0] & e[1:0]};
        @(negedge clk);
        low_pwr    = lp;
        cond_req   = c[1:0];
        cond_en    = e[1:0];
        sw_req     = c[2];
        esc_req    = c[3];
        main_pwr_n = ~c[4];
        @(negedge clk);
        cond_req = '0; sw_req = 1'b0; esc_req = 1'b0; main_pwr_n = 1'b1;
        if (exp != '0) begin
            chk("R10 reset starts next edge", rst_req, 1);
            chk("R1 R4 R5 R3 vector", vec, exp);
            chk("R3 cause", cause, 2);
            chk("R6 clock off", clk_en, 0);
            if (lp) chk("R2 reset in low power", rst_req, 1);
            for (int k = 1; k < RC; k++) begin
                @(negedge clk);
                chk("R10 reset length", rst_req, 1);
            end
            @(negedge clk);
            chk("R10 reset ends", rst_req, 0);
            chk("R6 clock back", clk_en, 1);
            chk("R3 idle vector", vec, 0);
            chk("R9 status loaded", status, exp);
            last_stat = exp;
        end else begin
            for (int k = 0; k < RC + 1; k++) begin
                chk("R1 masked request ignored", rst_req, 0);
                chk("R6 clock stays on", clk_en, 1);
                if (k < RC) @(negedge clk);
            end
            chk("R9 status held", status, last_stat);
        end
    endtask

    // Reset (software) at cycle ra, wakeup at cycle wa; report first service cycles.
    task automatic race(input logic lp, input int ra, input int wa, input string tag);
        int fr, fw;
        fr = -1; fw = -1;
        low_pwr = lp;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_req && fr < 0) fr = i;
            if (wake_o && fw < 0) fw = i;
            sw_req = (i == ra);
            wake   = (i == wa);
        end
        sw_req = 1'b0; wake = 1'b0; low_pwr = 1'b0;
        repeat (2) @(negedge clk);
        chk({tag, " reset serviced"}, (fr >= 0), 1);
        if (!lp) chk({tag, " wake ignored"}, (fw >= 0), 0);
        else begin
            chk({tag, " wake serviced"}, (fw >= 0), 1);
            if (ra <= wa) chk({tag, " reset before wake"}, (fr < fw), 1);
            else          chk({tag, " wake before reset"}, (fw < fr), 1);
        end
        last_stat = 5'b00100;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 reset-state request", rst_req, 0);
        chk("R6 reset-state clock", clk_en, 1);
        chk("R9 reset-state status", status, 0);
        chk("R7 reset-state wake", wake_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 32; c++)
            for (int e = 0; e < 4; e++)
                pulse(c, e, c[0] ^ e[1]);
        race(1'b1, 3, 3, "R8 same cycle");
        race(1'b1, 2, 3, "R7 reset one early");
        race(1'b1, 3, 2, "R7 wake one early");
        race(1'b1, 1, 3, "R7 reset two early");
        race(1'b1, 3, 1, "R7 wake two early");
        race(1'b0, 3, 2, "R11 wake outside low power");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule